// File: doc/BRIEF.md
# Pulse-Swallow Phase-Stepping Divider

This block divides a fast input clock down to a reference-rate square wave through a dual-modulus prescaler (divide by 10 or 11) and a modulus controller built from a program counter and a swallow counter. With default parameters the nominal division is 100, so a 60 MHz input yields a 600 kHz output. On request, one output cycle is stretched by a single input clock. The extra count makes the output's phase step back by one hundredth of a cycle (3.6 degrees).

A second divider with the same nominal ratio runs from the same clock but has no swallow input. Its output is the phase reference against which the steps are measured. Holding the request high stretches every output cycle. The divided output then runs one reference step slower, and after 100 cycles it has slipped one full reference cycle.

Top module: `phase_step_divider`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, both outputs are high with both dividers at cycle position 0. With no request applied, the rising edges of `div_out` and `ref_out` fall on the same input clock.
- R2: An output cycle with no swallow applied lasts 100 input clocks: `div_out` is high for the first 50 and low for the last 50.
- R3: `swallow_req` is sampled on the last input clock of each output cycle. When it is 1, the next output cycle lasts 101 clocks. The extra clock falls in its first prescaler cycle (modulus 11 instead of 10), so the high phase lasts 51 clocks.
- R4: Each applied swallow delays every later rising edge of `div_out` by one input clock against `ref_out`. At each rising edge of `div_out`, the reference has advanced (applied swallows mod 100) clocks past its own last rising edge.
- R5: With the request held high, every output cycle lasts 101 clocks. After 100 stretched cycles, the rising edges of the two outputs coincide again.
- R6: A request pulse that rises and falls strictly inside an output cycle, away from its last clock, has no effect: that cycle and the next one last 100 clocks.
- R7: `ref_out` always has a 100-clock period, high for the first 50 clocks, whatever `swallow_req` does.
- R8: A synchronous reset asserted in the middle of a run forces both outputs high on the next clock and restarts both dividers in phase with zero offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| swallow_req | input | 1 | Request to stretch the next output cycle by one input clock |
| div_out | output | 1 | Registered divided output, phase-steppable |
| ref_out | output | 1 | Registered reference output, fixed division |

## Verification
The embedded assertions check on every clock that the prescaler modulus changes only at a prescaler boundary. They also check that the swallow counter is loaded only at the end of an output cycle, following the sampled request, and that the high modulus is used only in the leading prescaler cycles. The reset state and where the reference output's edges fall are checked on every clock too. Cycle lengths, duty, the phase offset that accumulates over many swallows, and the full-cycle slip under a held request can only be shown by the bench's scenarios. The bench compares both outputs on every clock with an arithmetic model of cycle positions.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } pre_mod_e;

  function automatic int unsigned half_len(input int unsigned n);
    return n / 2;
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned PRE_LO = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  pre_mod_e mod_sel,
  output logic     pre_end
);

  localparam int unsigned CW = $clog2(PRE_LO + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  always_comb begin
    last_cnt = (mod_sel == MOD_HI) ? CW'(PRE_LO) : CW'(PRE_LO - 1);
    pre_end  = (cnt == last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (pre_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the modulus must not move in the middle of a prescaler cycle
  a_r3_mod_steady: assert property (@(posedge clk) disable iff (rst)
    !$past(pre_end) |-> $stable(mod_sel));

  // R2: the count never passes the high modulus
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PRE_LO));

endmodule

// File: rtl/psd_modulus_ctrl.sv
module psd_modulus_ctrl
  import psd_pkg::*;
#(
  parameter int unsigned PROG_CNT     = 10,
  parameter int unsigned SWAL_PER_REQ = 1,
  localparam int unsigned PW = $clog2(PROG_CNT),
  localparam int unsigned SW = $clog2(SWAL_PER_REQ + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_end,
  input  logic          swallow_req,
  output pre_mod_e      mod_sel,
  output logic          cycle_end,
  output logic [PW-1:0] prog_nxt
);

  logic [PW-1:0] prog;
  logic [SW-1:0] swal;

  always_comb begin
    cycle_end = pre_end && (prog == PW'(PROG_CNT - 1));
    if (cycle_end) begin
      prog_nxt = '0;
    end else if (pre_end) begin
      prog_nxt = prog + 1'b1;
    end else begin
      prog_nxt = prog;
    end
    mod_sel = (swal != '0) ? MOD_HI : MOD_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog <= '0;
      swal <= '0;
    end else begin
      prog <= prog_nxt;
      if (cycle_end) begin
        swal <= swallow_req ? SW'(SWAL_PER_REQ) : '0;
      end else if (pre_end && (swal != '0)) begin
        swal <= swal - 1'b1;
      end
    end
  end

  // R3: a request seen at the end of a cycle selects the high modulus next
  a_r3_load_on_req: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && swallow_req) |=> (mod_sel == MOD_HI));

  // R2: without a request the next cycle starts on the low modulus
  a_r2_plain_cycle: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !swallow_req) |=> (mod_sel == MOD_LO));

  // R3: the high modulus only occurs in the leading prescaler cycles
  a_r3_hi_early: assert property (@(posedge clk) disable iff (rst)
    (mod_sel == MOD_HI) |-> (prog < PW'(SWAL_PER_REQ)));

  // R6: away from the cycle end the swallow count can only drain
  a_r6_no_midcycle_load: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> (swal <= $past(swal)));

endmodule

// File: rtl/psd_square_reg.sv
module psd_square_reg #(
  parameter int unsigned W        = 4,
  parameter int unsigned HIGH_LEN = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_nxt,
  output logic         sq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq <= 1'b1;
    end else begin
      sq <= (cnt_nxt < W'(HIGH_LEN));
    end
  end

endmodule

// File: rtl/psd_ref_divider.sv
module psd_ref_divider
  import psd_pkg::*;
#(
  parameter int unsigned DIV = 100,
  localparam int unsigned RW = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst,
  output logic ref_out
);

  logic [RW-1:0] rcnt;
  logic [RW-1:0] rcnt_nxt;

  always_comb begin
    rcnt_nxt = (rcnt == RW'(DIV - 1)) ? '0 : rcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt <= '0;
    end else begin
      rcnt <= rcnt_nxt;
    end
  end

  psd_square_reg #(
    .W        (RW),
    .HIGH_LEN (half_len(DIV))
  ) i_ref_sq (
    .clk     (clk),
    .rst     (rst),
    .cnt_nxt (rcnt_nxt),
    .sq      (ref_out)
  );

  // R7: reference edges sit at fixed count positions
  a_r7_ref_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_out) |-> (rcnt == '0));

  a_r7_ref_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_out) |-> (rcnt == RW'(half_len(DIV))));

endmodule

// File: rtl/phase_step_divider.sv
module phase_step_divider
  import psd_pkg::*;
#(
  parameter int unsigned PRE_LO       = 10,
  parameter int unsigned PROG_CNT     = 10,
  parameter int unsigned SWAL_PER_REQ = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic swallow_req,
  output logic div_out,
  output logic ref_out
);

  localparam int unsigned NOM_DIV = PRE_LO * PROG_CNT;
  localparam int unsigned PW      = $clog2(PROG_CNT);

  pre_mod_e      mod_sel;
  logic          pre_end;
  logic          cycle_end;
  logic [PW-1:0] prog_nxt;

  psd_prescaler #(
    .PRE_LO (PRE_LO)
  ) i_pre (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (mod_sel),
    .pre_end (pre_end)
  );

  psd_modulus_ctrl #(
    .PROG_CNT     (PROG_CNT),
    .SWAL_PER_REQ (SWAL_PER_REQ)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pre_end     (pre_end),
    .swallow_req (swallow_req),
    .mod_sel     (mod_sel),
    .cycle_end   (cycle_end),
    .prog_nxt    (prog_nxt)
  );

  psd_square_reg #(
    .W        (PW),
    .HIGH_LEN (half_len(PROG_CNT))
  ) i_div_sq (
    .clk     (clk),
    .rst     (rst),
    .cnt_nxt (prog_nxt),
    .sq      (div_out)
  );

  psd_ref_divider #(
    .DIV (NOM_DIV)
  ) i_ref (
    .clk     (clk),
    .rst     (rst),
    .ref_out (ref_out)
  );

  // R8: reset drives both outputs high on the following clock
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (div_out && ref_out));

  // R1: every output cycle begins with a high output
  a_r1_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> div_out);

endmodule

// File: tb/test_phase_step_divider.sv
module test_phase_step_divider;

  localparam int CLK_PERIOD = 10;
  localparam int NOM        = 100;
  localparam int HALF       = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swallow_req = 1'b0;
  logic div_out;
  logic ref_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model of cycle positions
  int pos = 0, len = NOM, rpos = 0, applied = 0, cyc = 0;
  bit glitch_zone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_step_divider i_phase_step_divider (
    .clk         (clk),
    .rst         (rst),
    .swallow_req (swallow_req),
    .div_out     (div_out),
    .ref_out     (ref_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d pos %0d)", tag, act, exp, cyc, pos);
    end
  endtask

  // advance one clock and compare both outputs with the model
  task automatic step();
    bit exp_div, exp_ref;
    @(negedge clk);
    pos++;
    rpos = (rpos + 1) % NOM;
    if (pos == len) begin
      applied += len - NOM;
      pos = 0;
      len = NOM + (swallow_req ? 1 : 0);
      cyc++;
    end
    exp_div = (pos < HALF + (len - NOM));
    exp_ref = (rpos < HALF);
    chk(ref_out == exp_ref, "R7 reference level", ref_out, exp_ref);
    if (glitch_zone)
      chk(div_out == exp_div, "R6 mid-cycle pulse ignored", div_out, exp_div);
    else if (len == NOM)
      chk(div_out == exp_div, "R2 plain cycle level", div_out, exp_div);
    else
      chk(div_out == exp_div, "R3 stretched cycle level", div_out, exp_div);
    if (applied == 0 && len == NOM)
      chk(div_out == ref_out, "R1 in phase", div_out, ref_out);
    if (pos == 0) begin
      chk(rpos == applied % NOM, "R4 phase lag", rpos, applied % NOM);
      if (applied == NOM)
        chk(rpos == 0, "R5 full slip realigned", rpos, 0);
    end
  endtask

  // run one output cycle; request value is set early in the cycle
  task automatic run_cycle(input bit req_val, input bit glitch);
    int start_cyc;
    start_cyc = cyc;
    glitch_zone = glitch;
    while (cyc == start_cyc) begin
      step();
      if (cyc != start_cyc) break;
      if (pos == 10) swallow_req = req_val;
      if (glitch && pos == 20) swallow_req = 1'b1;
      if (glitch && pos == 40) swallow_req = req_val;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    swallow_req = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(div_out == 1'b1, "R8 reset div level", div_out, 1);
      chk(ref_out == 1'b1, "R8 reset ref level", ref_out, 1);
    end
    rst = 1'b0;
    pos = 0; len = NOM; rpos = 0; applied = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(div_out == 1'b1 && ref_out == 1'b1, "R1 reset state", {div_out, ref_out}, 3);
    rst = 1'b0;
    // quiet start
    for (int c = 0; c < 5; c++) run_cycle(1'b0, 1'b0);
    // sparse pattern of swallows
    for (int c = 0; c < 16; c++) run_cycle(c % 3 == 0, 1'b0);
    // request held high well past one full slip
    for (int c = 0; c < 120; c++) run_cycle(1'b1, 1'b0);
    // mid-cycle pulses that must be ignored
    for (int c = 0; c < 20; c++) run_cycle(1'b0, 1'b1);
    glitch_zone = 1'b0;
    for (int c = 0; c < 3; c++) run_cycle(1'b1, 1'b0);
    // reset in the middle of a cycle
    repeat (37) step();
    do_reset();
    for (int c = 0; c < 10; c++) run_cycle(c == 4, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule